// File: doc/BRIEF.md
# Flash program command sequencer

This block is the command front end of a NOR-style flash array controller. It watches host write cycles and starts a program operation only after an exact four-write sequence: two unlock writes, a program-setup write, and finally the write that carries the target address and data. Once that last write is taken, the block runs the program operation by itself for a fixed number of clock cycles. During that time it answers host reads with status bits instead of array data and holds its ready output low. When the operation ends it writes the new word into a small on-chip array and goes back to read mode.

A program operation can only clear bits. The stored word becomes the AND of the old word and the written data. If the written data asks for a stored 0 to become 1, a failure bit is raised in the status word. While the operation is running, every write is ignored except a suspend command. Suspend freezes the operation until a resume command arrives. An asynchronous reset stops any operation at once, returns the block to read mode and sets the array back to the erased state (all ones).

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, ready_o is 1, rdata_o is 0 and every array word reads as all ones.
- R2: In read mode, a read (rd_en_i high) places the word at array index addr_i[3:0] on rdata_o after the next rising clock edge. rdata_o holds its value when no read is made.
- R3: Programming starts only after these four writes in order: data 0xAA at address 0x555, data 0x55 at address 0x2AA, data 0xA0 at address 0x555, and then any write, which gives the target address and data. ready_o goes low on the edge that takes the fourth write.
- R4: During the unlock or setup steps, any write that does not match the expected address and data returns the block to read mode, and the writes that follow do not program anything.
- R5: ready_o stays low for exactly PROG_CYCLES clock cycles after the fourth write, not counting suspended cycles. It then returns high with no further host activity.
- R6: When an operation completes, the target word becomes the old word AND the written data. No bit ever changes from 0 to 1.
- R7: A read while an operation is active returns a status word. Bit 7 is the inverse of bit 7 of the target data. Bit 6 is 0 on the first status read after the operation starts and inverts on each later status read while the operation is not suspended. Bit 5 is 1 when the written data had a 1 where the stored word had a 0. All other bits are 0.
- R8: While an operation runs, every write other than data 0xB0 is ignored. This includes unlock writes: no partial unlock state survives to read mode.
- R9: Data 0xB0 written at any address while busy suspends the operation. ready_o stays low, the remaining cycle count is held, status bit 6 does not toggle, and all writes except data 0x30 are ignored. Data 0x30 resumes the operation with the cycles that were left.
- R10: Asserting rst_ni low during an operation ends it at once. ready_o goes high, and the target word keeps its erased value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one write per cycle |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | AW | Host address |
| wdata_i | input | DW | Host write data (command or program data) |
| rdata_o | output | DW | Registered read data or status word |
| ready_o | output | 1 | High in read mode, low while an operation is active or suspended |

## Verification
Read data and status words appear one edge after the read strobe. ready_o falls on the same edge that takes the fourth write. It rises PROG_CYCLES edges later, plus one edge for the suspend write and one for each edge spent suspended. A cycle-level reference model in the bench updates on the same edge as the design. ready_o and rdata_o are compared against it on every falling edge. Directed checks count the low-ready falling edges against the expected totals, so an off-by-one in the busy window, or a suspend that lets the counter slip, shows up as a wrong count.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_SETUP,
    ST_BUSY,
    ST_SUSP
  } fps_state_e;

  localparam logic [7:0]  CMD_UNL1   = 8'hAA;
  localparam logic [7:0]  CMD_UNL2   = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_SUSP   = 8'hB0;
  localparam logic [7:0]  CMD_RESUME = 8'h30;
  localparam logic [11:0] ADR_A      = 12'h555;
  localparam logic [11:0] ADR_B      = 12'h2AA;
endpackage

// File: rtl/fps_cmd_fsm.sv
module fps_cmd_fsm
  import fps_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int IDX_W       = 4,
  parameter int PROG_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output fps_state_e       state_o,
  output logic             accept_o,
  output logic             commit_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic [DW-1:0]    tgt_data_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [AW-1:0] A_ADR = AW'(ADR_A);
  localparam logic [AW-1:0] B_ADR = AW'(ADR_B);

  fps_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    data_q;
  logic [7:0]       cmd;

  assign cmd = wdata_i[7:0];

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept_o = 1'b0;
    commit_o = 1'b0;
    unique case (state_q)
      ST_READ:
        if (wr_en_i && addr_i == A_ADR && cmd == CMD_UNL1) state_d = ST_UNL1;
      ST_UNL1:
        if (wr_en_i) state_d = (addr_i == B_ADR && cmd == CMD_UNL2) ? ST_UNL2 : ST_READ;
      ST_UNL2:
        if (wr_en_i) state_d = (addr_i == A_ADR && cmd == CMD_PROG) ? ST_SETUP : ST_READ;
      ST_SETUP:
        if (wr_en_i) begin
          accept_o = 1'b1;
          state_d  = ST_BUSY;
          cnt_d    = CW'(PROG_CYCLES);
        end
      ST_BUSY:
        if (wr_en_i && cmd == CMD_SUSP) begin
          state_d = ST_SUSP;  // counter frozen
        end else if (cnt_q == CW'(1)) begin
          commit_o = 1'b1;
          state_d  = ST_READ;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      ST_SUSP:
        if (wr_en_i && cmd == CMD_RESUME) state_d = ST_BUSY;
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept_o) begin
        idx_q  <= addr_i[IDX_W-1:0];
        data_q <= wdata_i;
      end else if (commit_o) begin
        idx_q  <= '0;  // address no longer held
        data_q <= '0;
      end
    end
  end

  assign state_o    = state_q;
  assign tgt_idx_o  = idx_q;
  assign tgt_data_o = data_q;

  assert_setup_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> ($past(state_q) == ST_UNL2 || $past(state_q) == ST_SETUP));

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> (cnt_q != '0 && cnt_q <= CW'(PROG_CYCLES)));

  assert_cnt_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP) |=> $stable(cnt_q));
endmodule

// File: rtl/fps_array.sv
module fps_array #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_word_o,
  input  logic             prog_en_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [DW-1:0]    prog_data_i
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (prog_en_i) begin
      mem_q[prog_idx_i] <= mem_q[prog_idx_i] & prog_data_i;  // clear-only
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];

  assert_no_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |=> ((mem_q[$past(prog_idx_i)] & ~$past(mem_q[prog_idx_i])) == '0));
endmodule

// File: rtl/fps_status.sv
module fps_status
  import fps_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fps_state_e    state_i,
  input  logic          rd_en_i,
  input  logic          accept_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rd_word_i,
  input  logic          tgt_msb_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o
);
  logic          active;
  logic          tog_q, fail_q;
  logic [DW-1:0] rdata_q, stat;

  assign active = (state_i == ST_BUSY) || (state_i == ST_SUSP);

  always_comb begin
    stat    = '0;
    stat[7] = ~tgt_msb_i;
    stat[6] = tog_q;
    stat[5] = fail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      fail_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        tog_q  <= 1'b0;
        fail_q <= |(wdata_i & ~rd_word_i);  // attempt to raise a cleared bit
      end else if (rd_en_i && state_i == ST_BUSY) begin
        tog_q <= ~tog_q;
      end
      if (rd_en_i) rdata_q <= active ? stat : rd_word_i;
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = ~active;

  assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_i == ST_BUSY) |=> (tog_q != $past(tog_q)));

  assert_susp_tog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SUSP) |=> $stable(tog_q));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o
);
  localparam int IDX_W = $clog2(DEPTH);

  fps_state_e       state;
  logic             accept, commit;
  logic [IDX_W-1:0] tgt_idx;
  logic [DW-1:0]    tgt_data, rd_word;

  fps_cmd_fsm #(
    .AW(AW), .DW(DW), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .state_o    (state),
    .accept_o   (accept),
    .commit_o   (commit),
    .tgt_idx_o  (tgt_idx),
    .tgt_data_o (tgt_data)
  );

  fps_array #(
    .DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (addr_i[IDX_W-1:0]),
    .rd_word_o   (rd_word),
    .prog_en_i   (commit),
    .prog_idx_i  (tgt_idx),
    .prog_data_i (tgt_data)
  );

  fps_status #(
    .DW(DW)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .rd_en_i   (rd_en_i),
    .accept_i  (accept),
    .wdata_i   (wdata_i),
    .rd_word_i (rd_word),
    .tgt_msb_i (tgt_data[7]),
    .rdata_o   (rdata_o),
    .ready_o   (ready_o)
  );
endmodule

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  flash_prog_seq #(.AW(12), .DW(8), .DEPTH(16), .PROG_CYCLES(P)) u_flash_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready)
  );

  // reference model: 0 read, 1 unl1, 2 unl2, 3 setup, 4 busy, 5 suspended
  int         m_state, m_cnt, m_idx;
  logic [7:0] m_tdata, m_rd;
  logic       m_fail, m_tog;
  logic [7:0] m_mem [16];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_idx = 0; m_tdata = 0; m_rd = 0;
      m_fail = 0; m_tog = 0;
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
    end else begin
      if (rd_en) begin
        if (m_state >= 4) begin
          m_rd = {~m_tdata[7], m_tog, m_fail, 5'b0};
          if (m_state == 4) m_tog = ~m_tog;
        end else m_rd = m_mem[addr[3:0]];
      end
      case (m_state)
        0: if (wr_en && addr == 12'h555 && wdata == 8'hAA) m_state = 1;
        1: if (wr_en) m_state = (addr == 12'h2AA && wdata == 8'h55) ? 2 : 0;
        2: if (wr_en) m_state = (addr == 12'h555 && wdata == 8'hA0) ? 3 : 0;
        3: if (wr_en) begin
             m_idx = addr[3:0]; m_tdata = wdata;
             m_fail = |(wdata & ~m_mem[addr[3:0]]);
             m_tog = 0; m_cnt = P; m_state = 4;
           end
        4: if (wr_en && wdata == 8'hB0) m_state = 5;
           else if (m_cnt == 1) begin
             m_mem[m_idx] = m_mem[m_idx] & m_tdata;
             m_state = 0; m_cnt = 0; m_idx = 0; m_tdata = 0;
           end else m_cnt--;
        5: if (wr_en && wdata == 8'h30) m_state = 4;
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (ready !== (m_state < 4) || rdata !== m_rd) begin
        mismatched++;
        $display("FAIL %s model compare: ready=%0b rdata=%h expected ready=%0b rdata=%h",
                 phase, ready, rdata, (m_state < 4), m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    rd_en = 1; wr_en = 0; addr = a;
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, v2;
    int n, k;
    idle(3);
    rst_n = 1;
    phase = "R1";
    chk("R1 ready after reset", {7'b0, ready}, 8'h01);
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(12'h003, v); chk("R1 erased word", v, 8'hFF);

    phase = "R2";
    rd(12'h009, v); chk("R2 read word 9", v, 8'hFF);
    idle(2); chk("R2 rdata held", rdata, 8'hFF);

    phase = "R3";
    unlock();
    chk("R3 ready before fourth write", {7'b0, ready}, 8'h01);
    wr(12'h003, 8'hA5);
    chk("R3 ready low after fourth write", {7'b0, ready}, 8'h00);

    phase = "R7";
    rd(12'h003, v); chk("R7 first status", v, 8'h00);
    rd(12'h003, v); chk("R7 second status toggles", v, 8'h40);
    wait_ready(n);
    phase = "R6";
    rd(12'h003, v); chk("R6 programmed A5", v, 8'hA5);

    phase = "R5";
    unlock(); wr(12'h004, 8'h0F);
    wait_ready(n); chk("R5 busy cycles", 8'(n), 8'(P));
    rd(12'h004, v); chk("R5 word after completion", v, 8'h0F);

    phase = "R6";
    unlock(); wr(12'h003, 8'h5A);
    rd(12'h003, v); chk("R7 status with raise attempt", v, 8'hA0);
    wait_ready(n);
    rd(12'h003, v); chk("R6 AND of old and new", v, 8'h00);

    phase = "R8";
    unlock(); wr(12'h006, 8'h3C);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    wr(12'h006, 8'h00); wr(12'h555, 8'hF0);
    wait_ready(n); chk("R8 ignored writes keep timing", 8'(n + 5), 8'(P));
    rd(12'h006, v); chk("R8 target unaffected", v, 8'h3C);
    wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h006, 8'h00);
    chk("R8 no unlock survives", {7'b0, ready}, 8'h01);
    rd(12'h006, v); chk("R8 word unchanged", v, 8'h3C);

    phase = "R4";
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); wr(12'h555, 8'hA0); wr(12'h007, 8'h00);
    chk("R4 bad second write", {7'b0, ready}, 8'h01);
    wr(12'h555, 8'hAA); wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    wr(12'h555, 8'hA0); wr(12'h007, 8'h00);
    chk("R4 repeated first write", {7'b0, ready}, 8'h01);
    rd(12'h007, v); chk("R4 word 7 erased", v, 8'hFF);

    phase = "R9";
    unlock(); wr(12'h008, 8'h11);
    idle(3);
    wr(12'h123, 8'hB0);
    idle(30);
    chk("R9 ready low while suspended", {7'b0, ready}, 8'h00);
    wr(12'h008, 8'hF0);
    rd(12'h008, v); rd(12'h008, v2);
    chk("R9 status while suspended", v, 8'h80);
    chk("R9 bit 6 frozen", v2, v);
    wr(12'h000, 8'h30);
    wait_ready(k); chk("R9 remaining cycles", 8'(k), 8'(P - 3));
    rd(12'h008, v); chk("R9 word after resume", v, 8'h11);

    phase = "R10";
    unlock(); wr(12'h009, 8'h00);
    idle(2);
    rst_n = 0; #1;
    chk("R10 ready high on reset", {7'b0, ready}, 8'h01);
    @(negedge clk); rst_n = 1;
    rd(12'h009, v); chk("R10 aborted word erased", v, 8'hFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog %s actual=timeout expected=completion", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule